// File: doc/BRIEF.md
# Wormhole Input Port Controller

This block is the control side of a single input port in a flit-switched wormhole router. Flits coming in from the link land in a small FIFO. When a head flit reaches the front of that FIFO, the port asks an external route unit where the packet should go. It then bids for the switch toward that output. Once the bid is granted, it streams the packet's flits out in order, and every flit carries the output chosen for the head.

Forwarding is paced by a downstream credit counter. The counter drops by one for each flit sent and rises by one for each credit handed back. No flit leaves while the counter is at zero. When the tail flit leaves, the port gives up its output and goes back to idle. A head queued behind an unfinished packet has to wait its turn, because the FIFO is strictly in order. Each flit that leaves the FIFO, whether forwarded or discarded, returns one credit to the upstream neighbour. The crossbar and the switch arbiter live outside this block.

Top module: `wh_inport_ctrl`

## Requirements
- R1: After reset the port is idle. rc_req, sw_req, out_valid and up_credit are all low, and the credit counter holds CRED_MAX.
- R2: A flit offered with in_valid is stored in arrival order when the FIFO holds fewer than FIFO_DEPTH flits. A flit offered while the FIFO is full is discarded and never appears at the output.
- R3: The flit kind is coded on 2 bits: 2'b01 head, 2'b10 body, 2'b11 tail (2'b00 is handled as body). One cycle after a head reaches the front of the FIFO in the idle state, rc_req is raised with rc_dest equal to the head's payload. rc_req stays high, with rc_dest unchanged, until rc_valid is seen.
- R4: rc_valid during a route request captures rc_port. In the next cycle rc_req is low, sw_req is high, and sw_port equals the captured port.
- R5: No flit is forwarded before sw_grant. sw_req stays high until sw_grant is seen, and forwarding may start in the cycle after the grant.
- R6: Every flit of a granted packet is forwarded in FIFO order with its kind and payload unchanged. out_port equals the route bound for the head, so body and tail flits inherit it.
- R7: While the packet is active, out_valid is high exactly when the FIFO is non-empty and the credit count is non-zero.
- R8: The credit count falls by one for each forwarded flit and rises by one for each cred_ret cycle. If both happen in the same cycle, the count is unchanged. The count never rises above CRED_MAX.
- R9: up_credit is high in exactly those cycles in which a flit leaves the FIFO, whether forwarded or discarded.
- R10: In the cycle after a tail is forwarded, the port is idle: out_valid, sw_req and rc_req are all low. A head queued behind that packet gets no route request until then.
- R11: A body or tail flit at the front of the FIFO while the port is idle is discarded in that cycle, with no route request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming flit present |
| in_type | input | 2 | Incoming flit kind |
| in_data | input | DATA_W | Incoming flit payload |
| up_credit | output | 1 | Credit returned upstream (a flit left the FIFO) |
| rc_req | output | 1 | Route computation request |
| rc_dest | output | DATA_W | Head payload presented to the route unit |
| rc_valid | input | 1 | Route result valid |
| rc_port | input | $clog2(NPORTS) | Computed output port |
| sw_req | output | 1 | Switch request for the bound output |
| sw_port | output | $clog2(NPORTS) | Output port requested |
| sw_grant | input | 1 | Switch granted |
| cred_ret | input | 1 | Credit returned by the downstream buffer |
| out_valid | output | 1 | Flit forwarded this cycle |
| out_type | output | 2 | Forwarded flit kind |
| out_data | output | DATA_W | Forwarded flit payload |
| out_port | output | $clog2(NPORTS) | Output port of the forwarded flit |

## Verification
The bench builds the port with an 8-bit payload, five outputs, a four-entry FIFO and three downstream credits. Because there are fewer credits than FIFO entries, a four-flit packet runs the counter down to zero and stalls until a credit comes back. The four-entry FIFO also allows two short packets to queue back to back, which exposes head-of-line waiting, and it lets a fifth pushed flit hit the full condition. Every output port is swept with packet lengths two to four. Credits are returned either alongside each send or only when the counter is exhausted, and the expected valid pattern is computed arithmetically for every cycle.

// File: rtl/wh_pkg.sv
package wh_pkg;

   typedef enum logic [1:0] {
      FL_RSVD = 2'b00,
      FL_HEAD = 2'b01,
      FL_BODY = 2'b10,
      FL_TAIL = 2'b11
   } flit_kind_e;

   typedef enum logic [1:0] {
      PS_IDLE,
      PS_ROUTE,
      PS_WAIT,
      PS_ACTIVE
   } port_state_e;

endpackage

// File: rtl/wh_flit_fifo.sv
module wh_flit_fifo #(
   parameter int W     = 10,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] count;
   logic             do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rd_ptr];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/wh_credit_ctr.sv
module wh_credit_ctr #(
   parameter int CRED_MAX = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic give,
   output logic avail
);
   localparam int CW = $clog2(CRED_MAX + 1);

   logic [CW-1:0] cnt;

   assign avail = (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= CW'(CRED_MAX);
      end else begin
         case ({take, give})
            2'b10:   cnt <= cnt - 1'b1;
            2'b01:   cnt <= (cnt == CW'(CRED_MAX)) ? cnt : cnt + 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/wh_port_fsm.sv
module wh_port_fsm
   import wh_pkg::*;
#(
   parameter int PORT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              front_valid,
   input  logic [1:0]        front_kind,
   input  logic              rc_valid,
   input  logic [PORT_W-1:0] rc_port,
   input  logic              sw_grant,
   input  logic              credit_ok,
   output logic              rc_req,
   output logic              sw_req,
   output logic [PORT_W-1:0] route,
   output logic              send,
   output logic              drop
);
   port_state_e st;
   logic        is_head, is_tail;

   assign is_head = (flit_kind_e'(front_kind) == FL_HEAD);
   assign is_tail = (flit_kind_e'(front_kind) == FL_TAIL);

   assign rc_req = (st == PS_ROUTE);
   assign sw_req = (st == PS_WAIT);
   assign send   = (st == PS_ACTIVE) && front_valid && credit_ok;
   assign drop   = (st == PS_IDLE) && front_valid && !is_head;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= PS_IDLE;
         route <= '0;
      end else begin
         case (st)
            PS_IDLE:   if (front_valid && is_head) st <= PS_ROUTE;
            PS_ROUTE:  if (rc_valid) begin
                          route <= rc_port;
                          st    <= PS_WAIT;
                       end
            PS_WAIT:   if (sw_grant) st <= PS_ACTIVE;
            PS_ACTIVE: if (send && is_tail) st <= PS_IDLE;
            default:   st <= PS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/wh_inport_ctrl.sv
module wh_inport_ctrl #(
   parameter int DATA_W     = 8,
   parameter int NPORTS     = 5,
   parameter int FIFO_DEPTH = 4,
   parameter int CRED_MAX   = 3,
   localparam int PORT_W    = $clog2(NPORTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        in_type,
   input  logic [DATA_W-1:0] in_data,
   output logic              up_credit,
   output logic              rc_req,
   output logic [DATA_W-1:0] rc_dest,
   input  logic              rc_valid,
   input  logic [PORT_W-1:0] rc_port,
   output logic              sw_req,
   output logic [PORT_W-1:0] sw_port,
   input  logic              sw_grant,
   input  logic              cred_ret,
   output logic              out_valid,
   output logic [1:0]        out_type,
   output logic [DATA_W-1:0] out_data,
   output logic [PORT_W-1:0] out_port
);
   localparam int ENTRY_W = DATA_W + 2;

   generate
      if (NPORTS < 2)     begin : g_bad_ports $error("NPORTS must be at least 2"); end
      if (FIFO_DEPTH < 2) begin : g_bad_depth $error("FIFO_DEPTH must be at least 2"); end
      if (CRED_MAX < 1)   begin : g_bad_cred  $error("CRED_MAX must be at least 1"); end
      if (DATA_W < 1)     begin : g_bad_width $error("DATA_W must be at least 1"); end
   endgenerate

   logic [ENTRY_W-1:0] front;
   logic               empty, full;
   logic               send, drop, credit_ok;
   logic [PORT_W-1:0]  route;

   wh_flit_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (in_valid),
      .wdata ({in_type, in_data}),
      .pop   (send | drop),
      .rdata (front),
      .empty (empty),
      .full  (full)
   );

   wh_credit_ctr #(.CRED_MAX(CRED_MAX)) u_cred (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (send),
      .give  (cred_ret),
      .avail (credit_ok)
   );

   wh_port_fsm #(.PORT_W(PORT_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .front_valid (!empty),
      .front_kind  (front[ENTRY_W-1 -: 2]),
      .rc_valid    (rc_valid),
      .rc_port     (rc_port),
      .sw_grant    (sw_grant),
      .credit_ok   (credit_ok),
      .rc_req      (rc_req),
      .sw_req      (sw_req),
      .route       (route),
      .send        (send),
      .drop        (drop)
   );

   logic unused_full;
   assign unused_full = full;

   assign up_credit = send | drop;
   assign rc_dest   = front[DATA_W-1:0];
   assign sw_port   = route;
   assign out_valid = send;
   assign out_type  = front[ENTRY_W-1 -: 2];
   assign out_data  = front[DATA_W-1:0];
   assign out_port  = route;
endmodule

// File: rtl/wh_inport_chk.sv
module wh_inport_chk
   import wh_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int NPORTS   = 5,
   parameter int CRED_MAX = 3,
   localparam int PORT_W  = $clog2(NPORTS),
   localparam int CW      = $clog2(CRED_MAX + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rc_req,
   input logic [DATA_W-1:0] rc_dest,
   input logic              rc_valid,
   input logic [PORT_W-1:0] rc_port,
   input logic              sw_req,
   input logic [PORT_W-1:0] sw_port,
   input logic              cred_ret,
   input logic              out_valid,
   input logic [1:0]        out_type,
   input logic              up_credit
);
   logic [CW-1:0] seen_cred;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_cred <= CW'(CRED_MAX);
      end else begin
         case ({out_valid, cred_ret})
            2'b10:   seen_cred <= seen_cred - 1'b1;
            2'b01:   seen_cred <= (seen_cred == CW'(CRED_MAX)) ? seen_cred : seen_cred + 1'b1;
            default: seen_cred <= seen_cred;
         endcase
      end
   end

   // R3
   route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rc_req && !rc_valid |=> rc_req && $stable(rc_dest));

   // R4
   route_bind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rc_req && rc_valid |=> !rc_req && sw_req && (sw_port == $past(rc_port)));

   // R5
   phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rc_req, sw_req, out_valid}));

   // R8
   credit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (seen_cred != '0));

   // R9
   upstream_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> up_credit);

   // R10
   tail_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && (flit_kind_e'(out_type) == FL_TAIL) |=> !out_valid && !sw_req && !rc_req);
endmodule

bind wh_inport_ctrl wh_inport_chk #(
   .DATA_W   (DATA_W),
   .NPORTS   (NPORTS),
   .CRED_MAX (CRED_MAX)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rc_req    (rc_req),
   .rc_dest   (rc_dest),
   .rc_valid  (rc_valid),
   .rc_port   (rc_port),
   .sw_req    (sw_req),
   .sw_port   (sw_port),
   .cred_ret  (cred_ret),
   .out_valid (out_valid),
   .out_type  (out_type),
   .up_credit (up_credit)
);

// File: tb/sim_wh_inport_ctrl.sv
module sim_wh_inport_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int DW  = 8;
   localparam int NP  = 5;
   localparam int DEP = 4;
   localparam int CM  = 3;
   localparam int PW  = $clog2(NP);

   localparam logic [1:0] K_HEAD = 2'b01;
   localparam logic [1:0] K_BODY = 2'b10;
   localparam logic [1:0] K_TAIL = 2'b11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [1:0]    in_type = '0;
   logic [DW-1:0] in_data = '0;
   logic          up_credit;
   logic          rc_req;
   logic [DW-1:0] rc_dest;
   logic          rc_valid = 1'b0;
   logic [PW-1:0] rc_port = '0;
   logic          sw_req;
   logic [PW-1:0] sw_port;
   logic          sw_grant = 1'b0;
   logic          cred_ret = 1'b0;
   logic          out_valid;
   logic [1:0]    out_type;
   logic [DW-1:0] out_data;
   logic [PW-1:0] out_port;

   int n_checks = 0;
   int n_fails  = 0;
   int mcred    = CM;

   always #(CLK_PERIOD/2) clk = ~clk;

   wh_inport_ctrl #(.DATA_W(DW), .NPORTS(NP), .FIFO_DEPTH(DEP), .CRED_MAX(CM)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_type(in_type), .in_data(in_data),
      .up_credit(up_credit), .rc_req(rc_req), .rc_dest(rc_dest), .rc_valid(rc_valid),
      .rc_port(rc_port), .sw_req(sw_req), .sw_port(sw_port), .sw_grant(sw_grant),
      .cred_ret(cred_ret), .out_valid(out_valid), .out_type(out_type), .out_data(out_data),
      .out_port(out_port)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   task automatic push(input logic [1:0] kind, input int data);
      @(negedge clk);
      in_valid = 1'b1;
      in_type  = kind;
      in_data  = DW'(data);
   endtask

   task automatic push_end();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // mode 0: credit returned alongside every send; mode 1: only when exhausted
   task automatic serve(input int p, input int len, input int base, input int mode);
      int n = 0;
      int got = 0;
      int ret;
      int sent;
      while (!rc_req && n < 50) begin @(negedge clk); n++; end
      chk("R3 route request raised", int'(rc_req), 1);
      chk("R3 rc_dest carries head payload", int'(rc_dest), base & 8'hff);
      chk("R5 no switch request while routing", int'(sw_req), 0);
      rc_valid = 1'b1;
      rc_port  = PW'(p);
      @(negedge clk);
      rc_valid = 1'b0;
      chk("R4 switch request after route", int'(sw_req), 1);
      chk("R4 sw_port is computed route", int'(sw_port), p);
      chk("R4 route request dropped", int'(rc_req), 0);
      @(negedge clk);
      chk("R5 request held without grant", int'(sw_req), 1);
      chk("R5 nothing forwarded before grant", int'(out_valid), 0);
      sw_grant = 1'b1;
      @(negedge clk);
      sw_grant = 1'b0;
      n = 0;
      while (got < len && n < 100) begin
         chk("R7 out_valid follows credit", int'(out_valid), (mcred > 0) ? 1 : 0);
         chk("R9 up_credit on dequeue", int'(up_credit), int'(out_valid));
         chk("R10 no route request mid-packet", int'(rc_req), 0);
         sent = int'(out_valid);
         if (out_valid) begin
            chk("R6 payload order", int'(out_data), (base + got) & 8'hff);
            chk("R6 flit kind", int'(out_type),
                (got == 0) ? int'(K_HEAD) : (got == len - 1) ? int'(K_TAIL) : int'(K_BODY));
            chk("R6 inherited out_port", int'(out_port), p);
            got++;
         end
         ret = (mode == 0) ? sent : ((mcred == 0) ? 1 : 0);
         cred_ret = ret[0];
         mcred = mcred - sent + ret;
         if (mcred > CM) mcred = CM;
         @(negedge clk);
         n++;
      end
      cred_ret = 1'b0;
      chk("R6 whole packet forwarded", got, len);
      chk("R10 idle after tail: out_valid", int'(out_valid), 0);
      chk("R10 idle after tail: sw_req", int'(sw_req), 0);
      chk("R10 idle after tail: rc_req", int'(rc_req), 0);
      while (mcred < CM) begin
         cred_ret = 1'b1;
         mcred++;
         @(negedge clk);
      end
      cred_ret = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fails++;
      $display("FAIL R1 watchdog expired actual=0 expected=1");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset rc_req", int'(rc_req), 0);
      chk("R1 reset sw_req", int'(sw_req), 0);
      chk("R1 reset out_valid", int'(out_valid), 0);
      chk("R1 reset up_credit", int'(up_credit), 0);

      // R1 reset credit = CRED_MAX: 4-flit packet must stall after CM flits
      push(K_HEAD, 40); push(K_BODY, 41); push(K_BODY, 42); push(K_TAIL, 43); push_end();
      serve(0, 4, 40, 1);

      // R6 R7 sweep of every output and packet length
      for (int p = 0; p < NP; p++) begin
         for (int len = 2; len <= 4; len++) begin
            int base = p * 20 + len * 5 + 60;
            push(K_HEAD, base);
            for (int i = 1; i < len - 1; i++) push(K_BODY, base + i);
            push(K_TAIL, base + len - 1);
            push_end();
            serve(p, len, base, (p + len) % 2);
         end
      end

      // R10 head-of-line: second packet waits behind the first
      push(K_HEAD, 100); push(K_TAIL, 101); push(K_HEAD, 110); push(K_TAIL, 111); push_end();
      serve(2, 2, 100, 0);
      serve(3, 2, 110, 1);

      // R11 stray body and tail at idle are discarded
      push(K_BODY, 55); push_end();
      chk("R11 stray body popped", int'(up_credit), 1);
      chk("R11 no route request for body", int'(rc_req), 0);
      chk("R11 stray body not forwarded", int'(out_valid), 0);
      @(negedge clk);
      chk("R11 fifo empty after drop", int'(up_credit), 0);
      push(K_TAIL, 56); push_end();
      chk("R11 stray tail popped", int'(up_credit), 1);
      chk("R11 no route request for tail", int'(rc_req), 0);
      @(negedge clk);

      // R2 fifth flit into a full FIFO is lost
      push(K_HEAD, 200); push(K_BODY, 201); push(K_BODY, 202); push(K_TAIL, 203);
      push(K_BODY, 250); push_end();
      serve(1, 4, 200, 0);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk("R2 overflow flit never forwarded", int'(out_valid), 0);
         chk("R2 overflow flit never dequeued", int'(up_credit), 0);
         chk("R2 no request from lost flit", int'(rc_req), 0);
      end

      // R8 credit saturates at CRED_MAX: extra return must not allow a 4th send
      cred_ret = 1'b1;
      @(negedge clk);
      cred_ret = 1'b0;
      push(K_HEAD, 30); push(K_BODY, 31); push(K_BODY, 32); push(K_TAIL, 33); push_end();
      serve(4, 4, 30, 1);

      report();
   end
endmodule